// File: doc/BRIEF.md
# Input Arrival Order Detector

This block watches two level inputs, `a` and `b`, that come from outside the clock domain, and reports whether `a` was the first of the two to rise on the way to the combination where both are high. The output `z` is high only while both inputs are high, and only if `a` got there first. If `b` rose first and `a` followed, `z` stays low for the whole time both are high.

Both inputs pass through their own two-flop synchronizer. A registered state machine then remembers the path the pair took through the four input combinations. The block expects the inputs to change one at a time, with the circuit settled between changes. If the sampled pair shows both inputs changing in the same cycle, the block raises a one-cycle `illegal_change` pulse. It then treats any resulting both-high state as `b`-first, so `z` stays low.

`z` comes straight from a flop and moves at most once per input change, so it never shows a brief false pulse while the machine passes between settled states.

Top module: `arrival_order_detector`

## Requirements
- R1: `z` is 1 only when the synchronized `a` and `b` were both 1 on the previous clock edge.
- R2: Reaching both-high from the combination a=1,b=0 (a rose first) gives `z`=1, for as long as both stay high.
- R3: Reaching both-high from the combination a=0,b=1 (b rose first) gives `z`=0, for as long as both stay high.
- R4: Leaving both-high, by either input dropping, clears `z`. Returning to a=0,b=0 forgets the order.
- R5: Going from both-high to a=1,b=0 and back to both-high counts as `b` arriving after `a`, so `z` is 1 again.
- R6: Going from both-high to a=0,b=1 and back to both-high counts as `a` arriving after `b`, so `z` stays 0.
- R7: When both synchronized inputs differ from their values on the previous clock edge, `illegal_change` is 1 for exactly one cycle. A both-high state reached this way gives `z`=0.
- R8: Synchronous active-high `rst` puts the machine in the a=0,b=0 state with `z`=0 and `illegal_change`=0.
- R9: `z` and `illegal_change` respond on the third rising edge after an input change (two synchronizer stages plus the state register). `z` makes at most one transition per input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 1 | First level input (asynchronous) |
| b | input | 1 | Second level input (asynchronous) |
| z | output | 1 | High while both are high and `a` rose first |
| illegal_change | output | 1 | One-cycle pulse when both sampled inputs changed together |

## Verification
The order properties assume that each input combination stays stable for at least two clock cycles. That way every combination on the path appears in the synchronized pair, and the previous sampled pair shows where the machine came from. The stimulus holds each combination for six cycles. Most steps flip exactly one input. A both-input flip is applied only on purpose, to exercise the `illegal_change` path and its forced `b`-first outcome.

// File: rtl/ao_pkg.sv
package ao_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int IN_WIDTH    = 2;

    typedef struct packed {
        logic a;
        logic b;
    } pair_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_A_ONLY  = 3'd1,
        ST_B_ONLY  = 3'd2,
        ST_BOTH_AF = 3'd3,
        ST_BOTH_BF = 3'd4
    } ord_state_e;

    // Input levels that each state stands for.
    function automatic pair_t levels_of(input ord_state_e s);
        pair_t p;
        case (s)
            ST_A_ONLY:              p = '{a: 1'b1, b: 1'b0};
            ST_B_ONLY:              p = '{a: 1'b0, b: 1'b1};
            ST_BOTH_AF, ST_BOTH_BF: p = '{a: 1'b1, b: 1'b1};
            default:                p = '{a: 1'b0, b: 1'b0};
        endcase
        return p;
    endfunction

    // Next state from the present state and the newly sampled pair.
    function automatic ord_state_e next_of(input ord_state_e s, input pair_t cur);
        ord_state_e n;
        unique case ({cur.a, cur.b})
            2'b00: n = ST_IDLE;
            2'b10: n = ST_A_ONLY;
            2'b01: n = ST_B_ONLY;
            default: begin
                if (s == ST_A_ONLY || s == ST_BOTH_AF) n = ST_BOTH_AF;
                else                                   n = ST_BOTH_BF;
            end
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ao_sync.sv
module ao_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/ao_order_fsm.sv
module ao_order_fsm
    import ao_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t cur,
    output logic  z,
    output logic  illegal_change
);
    ord_state_e state_q, state_d;
    pair_t      prev;
    logic       both_moved;

    always_comb begin
        prev       = levels_of(state_q);
        both_moved = (prev.a != cur.a) && (prev.b != cur.b);
        state_d    = next_of(state_q, cur);
        // A simultaneous arrival at both-high carries no valid order.
        if (both_moved && cur.a && cur.b) state_d = ST_BOTH_BF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            z              <= 1'b0;
            illegal_change <= 1'b0;
        end else begin
            state_q        <= state_d;
            z              <= (state_d == ST_BOTH_AF);
            illegal_change <= both_moved;
        end
    end
endmodule

// File: rtl/arrival_order_detector.sv
module arrival_order_detector
    import ao_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic b,
    output logic z,
    output logic illegal_change
);
    logic [IN_WIDTH-1:0] sync_q;
    logic                a_s;
    logic                b_s;
    pair_t               cur;

    ao_sync #(
        .WIDTH  (IN_WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({a, b}),
        .q   (sync_q)
    );

    assign a_s   = sync_q[1];
    assign b_s   = sync_q[0];
    assign cur.a = a_s;
    assign cur.b = b_s;

    ao_order_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .cur            (cur),
        .z              (z),
        .illegal_change (illegal_change)
    );
endmodule

// File: rtl/ao_checker.sv
module ao_checker (
    input logic clk,
    input logic rst,
    input logic a_s,
    input logic b_s,
    input logic z,
    input logic illegal_change
);
    p_z_only_both_r1: assert property (@(posedge clk) disable iff (rst)
        z |-> $past(a_s && b_s));

    p_a_first_r2: assert property (@(posedge clk) disable iff (rst)
        (a_s && b_s && $past(a_s && !b_s)) |=> z);

    p_b_first_r3: assert property (@(posedge clk) disable iff (rst)
        (a_s && b_s && $past(!a_s && b_s)) |=> !z);

    p_leave_clears_r4: assert property (@(posedge clk) disable iff (rst)
        !(a_s && b_s) |=> !z);

    p_illegal_r7: assert property (@(posedge clk) disable iff (rst)
        ((a_s != $past(a_s)) && (b_s != $past(b_s))) |=> illegal_change);

    p_illegal_z_r7: assert property (@(posedge clk) disable iff (rst)
        (a_s && b_s && $past(!a_s && !b_s)) |=> !z);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!z && !illegal_change));
endmodule

bind arrival_order_detector ao_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .a_s            (a_s),
    .b_s            (b_s),
    .z              (z),
    .illegal_change (illegal_change)
);

// File: tb/sim_arrival_order_detector.sv
`timescale 1ns/1ps
module sim_arrival_order_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a   = 1'b0;
    logic b   = 1'b0;
    logic z;
    logic illegal_change;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [1:0] m_ab    = 2'b00;
    logic       m_first = 1'b0;

    always #4 clk = ~clk;

    arrival_order_detector u0 (
        .clk            (clk),
        .rst            (rst),
        .a              (a),
        .b              (b),
        .z              (z),
        .illegal_change (illegal_change)
    );

    function automatic logic model_first(input logic [1:0] prv, input logic [1:0] nxt,
                                         input logic was_first);
        if (nxt != 2'b11)      return 1'b0;
        if (prv == 2'b10)      return 1'b1;
        if (prv == 2'b11)      return was_first;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a pair, watch six cycles, check the settled result.
    task automatic step(input logic [1:0] nxt, input string req);
        logic exp_first;
        logic both;
        int   pulses;
        int   z_moves;
        logic z_last;
        both      = (nxt[1] != m_ab[1]) && (nxt[0] != m_ab[0]);
        exp_first = both ? 1'b0 : model_first(m_ab, nxt, m_first);
        z_last    = z;
        pulses    = 0;
        z_moves   = 0;
        a = nxt[1];
        b = nxt[0];
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (illegal_change) pulses++;
            if (z !== z_last) z_moves++;
            z_last = z;
        end
        m_ab    = nxt;
        m_first = exp_first;
        check({req, " z"}, z, exp_first);
        check_int({req, " R7 illegal pulses"}, pulses, both ? 1 : 0);
        checks++;
        if (z_moves > 1) begin
            errors++;
            $display("FAIL R9 z transitions actual=%0d expected<=1", z_moves);
        end
    endtask

    task automatic latency_check;
        // From 10 to 11: z must rise on the third edge after the change.
        step(2'b00, "R4");
        step(2'b10, "R2");
        b = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 z before third edge", z, 1'b0);
        @(negedge clk);
        check("R9 z after third edge", z, 1'b1);
        repeat (3) @(negedge clk);
        m_ab    = 2'b11;
        m_first = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R8 reset z", z, 1'b0);
        check("R8 reset illegal_change", illegal_change, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        step(2'b10, "R1 a only");
        step(2'b11, "R2 a first");
        step(2'b10, "R4 drop b");
        step(2'b11, "R5 b re-arrives");
        step(2'b01, "R4 drop a");
        step(2'b11, "R6 a re-arrives");
        step(2'b10, "R4 drop b");
        step(2'b00, "R4 back to idle");
        step(2'b01, "R1 b only");
        step(2'b11, "R3 b first");
        step(2'b10, "R4 drop b");
        step(2'b11, "R5 b after a");
        step(2'b00, "R7 both drop");
        step(2'b11, "R7 both rise");
        step(2'b01, "R4 drop a");
        step(2'b10, "R7 swap");
        step(2'b11, "R2 a first again");
        latency_check();

        for (int n = 0; n < 400; n++) begin
            logic [1:0] nxt;
            int r;
            r = $urandom_range(0, 7);
            if (r == 0)      nxt = ~m_ab;
            else if (r < 4)  nxt = m_ab ^ 2'b10;
            else             nxt = m_ab ^ 2'b01;
            step(nxt, "R2/R3 random");
        end

        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 reset mid-run z", z, 1'b0);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule